// File: doc/BRIEF.md
# Multiplexed LCD Scan Timing Generator

This block produces the digital scan timing for a multiplexed dot-matrix LCD with up to 32 common lines and 48 segment lines. It advances by one step on every edge of its clock, which is a 32.768 kHz tick. The common lines are selected one at a time. For each common slot the block fetches one row of segment bits from an external display RAM through a synchronous read port. Each frame is 256 ticks long, so one frame lasts 1/128 s. The drive polarity flips at every frame boundary, which gives a 64 Hz alternation with no DC component on the glass.

For every common and segment pin the block emits a 3-bit rail code. The analog driver uses that code to pick a bias rail, where code 0 is the ground rail and code `a` is the top rail of a 1/`a` bias ladder. Run-time controls set the duty (1/16 or 1/32), the bias (1/5 or 1/7) and whether the display is on. The charge pump, the resistor ladder and the analog levels themselves are outside this block.

Top module: `lcd_mux_scan`

## Requirements
- R1: After reset the frame counter is 0, the polarity is 0, the latched duty is 1/16 and the latched row is all zeros. In the first slot, with the display on, common 0 carries its select code and every segment carries its non-select code.
- R2: A frame is 256 ticks. In 1/16 duty each slot is 16 ticks and commons 0 to 15 are selected in ascending order. At most one common carries the select code at any time.
- R3: In 1/16 duty, commons 16 to 31 always carry the common non-select code.
- R4: In 1/32 duty each slot is 8 ticks and commons 0 to 31 are selected in ascending order.
- R5: The polarity flips on the edge that wraps the frame counter from 255 to 0. With top rail `a`, the common select code is `a` at polarity 0 and 0 at polarity 1. The common non-select code is 1 at polarity 0 and `a-1` at polarity 1.
- R6: `bias7`=0 gives `a`=5 and `bias7`=1 gives `a`=7. A change of bias appears in the codes in the same cycle.
- R7: Segment pin j follows bit j of the latched row. A 1 gives the segment select code, which is 0 at polarity 0 and `a` at polarity 1. A 0 gives the segment non-select code, which is 2 at polarity 0 and `a-2` at polarity 1.
- R8: With `disp_on`=0, every common and segment code is 0 in the same cycle. Scan timing keeps running during that time.
- R9: In the tick at position slot_len-2 of each slot, `ram_rd` is 1 and `ram_addr` holds the next common index. That index wraps to 0 after the last scanned common. The data returned on the next tick is latched as the row for the following slot. `ram_rd` is 0 in all other ticks.
- R10: The `duty32` input is sampled only on the frame-wrap edge. A change in the middle of a frame does not alter the slot length or the common order until the next frame.
- R11: The code for pin k sits at bits [3k+2:3k] of `com_lvl` or `seg_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz scan tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_on | input | 1 | 1 drives the panel, 0 forces every code to the ground rail |
| duty32 | input | 1 | 1 selects 1/32 duty, 0 selects 1/16; sampled at frame start |
| bias7 | input | 1 | 1 selects 1/7 bias, 0 selects 1/5 |
| ram_rd | output | 1 | Display RAM read strobe |
| ram_addr | output | 5 | Row address for the read, equal to a common index |
| ram_data | input | 48 | Row data from the synchronous RAM, valid one tick after the read |
| com_lvl | output | 96 | Rail codes for the 32 commons, 3 bits each |
| seg_lvl | output | 144 | Rail codes for the 48 segments, 3 bits each |

## Verification
A fault in the frame counter or in the slot arithmetic moves the select code to the wrong common within one slot, which is 8 or 16 ticks. A polarity fault inverts every code at the next frame wrap. A fault in the prefetch address or in the row latch shows up as a wrong segment pattern from the start of the next slot. A duty latch that follows the input directly changes the common order in the same cycle that `duty32` moves mid-frame. The reference model compares all 80 codes and the RAM port on every tick, so each of these faults is reported within one slot of the cycle where it arises.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  function automatic lvl_t top_rail(input logic bias7);
    return bias7 ? lvl_t'(7) : lvl_t'(5);
  endfunction

  // common codes: select at the outer rail, non-select one step inside
  function automatic lvl_t com_code(input logic bias7, input logic pol, input logic sel);
    lvl_t a;
    a = top_rail(bias7);
    if (sel) return pol ? lvl_t'(0) : a;
    return pol ? lvl_t'(a - lvl_t'(1)) : lvl_t'(1);
  endfunction

  // segment codes: select opposite to the common, non-select two steps inside
  function automatic lvl_t seg_code(input logic bias7, input logic pol, input logic on);
    lvl_t a;
    a = top_rail(bias7);
    if (on) return pol ? a : lvl_t'(0);
    return pol ? lvl_t'(a - lvl_t'(2)) : lvl_t'(2);
  endfunction
endpackage

// File: rtl/lcd_scan_timebase.sv
module lcd_scan_timebase #(
  parameter int FRAME_TICKS = 256,
  parameter int COM_N       = 32,
  localparam int CNT_W = $clog2(FRAME_TICKS),
  localparam int IDX_W = $clog2(COM_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             duty32,
  output logic             pol,
  output logic             duty_q,
  output logic [IDX_W-1:0] slot_idx,
  output logic [IDX_W-1:0] next_idx,
  output logic             slot_last,
  output logic             prefetch,
  output logic             frame_first
);
  localparam int SH32 = CNT_W - IDX_W;
  localparam int SH16 = SH32 + 1;
  localparam logic [CNT_W-1:0] MASK32 = CNT_W'((1 << SH32) - 1);
  localparam logic [CNT_W-1:0] MASK16 = CNT_W'((1 << SH16) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_TICKS - 1);
  localparam logic [IDX_W-1:0] IDX32_MAX = IDX_W'(COM_N - 1);
  localparam logic [IDX_W-1:0] IDX16_MAX = IDX_W'(COM_N / 2 - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] mask;
  logic             frame_wrap;

  assign mask        = duty_q ? MASK32 : MASK16;
  assign pos         = cnt & mask;
  assign slot_idx    = duty_q ? IDX_W'(cnt >> SH32) : IDX_W'(cnt >> SH16);
  assign slot_last   = (pos == mask);
  assign prefetch    = (pos == mask - CNT_W'(1));
  assign next_idx    = (slot_idx + IDX_W'(1)) & (duty_q ? IDX32_MAX : IDX16_MAX);
  assign frame_wrap  = (cnt == CNT_MAX);
  assign frame_first = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      pol    <= 1'b0;
      duty_q <= 1'b0;
    end else begin
      cnt <= frame_wrap ? '0 : cnt + CNT_W'(1);
      if (frame_wrap) begin
        pol    <= ~pol;
        duty_q <= duty32;
      end
    end
  end

  // R5: polarity only moves at a frame start
  a_r5_pol_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pol) |-> frame_first);
  // R10: duty latch only moves at a frame start
  a_r10_duty_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(duty_q) |-> frame_first);
  // R2: slot index advances by at most one per tick or restarts at 0
  a_r2_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(slot_idx) |-> (slot_idx == '0) || (slot_idx == $past(slot_idx) + IDX_W'(1)));
endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch #(
  parameter int COM_N = 32,
  parameter int SEG_N = 48,
  localparam int IDX_W = $clog2(COM_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prefetch,
  input  logic             slot_last,
  input  logic [IDX_W-1:0] next_idx,
  input  logic [SEG_N-1:0] ram_data,
  output logic             ram_rd,
  output logic [IDX_W-1:0] ram_addr,
  output logic [SEG_N-1:0] row_q
);
  assign ram_rd   = prefetch;
  assign ram_addr = prefetch ? next_idx : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else if (slot_last) row_q <= ram_data;
  end

  // R9: the row only changes on entry to a new slot
  a_r9_row_at_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(row_q) |-> $past(slot_last));
  // R9: a read is always followed one tick later by the slot's last tick
  a_r9_read_then_latch: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd |=> slot_last);
endmodule

// File: rtl/lcd_scan_drive.sv
module lcd_scan_drive
  import lcd_scan_pkg::*;
#(
  parameter int COM_N = 32,
  parameter int SEG_N = 48,
  localparam int IDX_W = $clog2(COM_N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_on,
  input  logic               bias7,
  input  logic               pol,
  input  logic               duty_q,
  input  logic [IDX_W-1:0]   slot_idx,
  input  logic [SEG_N-1:0]   row_q,
  output logic [COM_N-1:0]   com_sel_vec,
  output logic [COM_N*LVL_W-1:0] com_lvl,
  output logic [SEG_N*LVL_W-1:0] seg_lvl
);
  localparam int HALF = COM_N / 2;

  for (genvar k = 0; k < COM_N; k++) begin : g_com
    logic in_scan;
    if (k < HALF) begin : g_low
      assign in_scan = 1'b1;
    end else begin : g_high
      assign in_scan = duty_q;
    end
    assign com_sel_vec[k] = in_scan && (slot_idx == IDX_W'(k));
    assign com_lvl[k*LVL_W +: LVL_W] =
      disp_on ? com_code(bias7, pol, com_sel_vec[k]) : lvl_t'(0);
  end

  for (genvar j = 0; j < SEG_N; j++) begin : g_seg
    assign seg_lvl[j*LVL_W +: LVL_W] =
      disp_on ? seg_code(bias7, pol, row_q[j]) : lvl_t'(0);
  end

  // R2: never more than one common selected
  a_r2_one_com: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_sel_vec));
  // R3: upper commons idle in 1/16 duty
  a_r3_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !duty_q |-> (com_sel_vec[COM_N-1:HALF] == '0));
endmodule

// File: rtl/lcd_mux_scan.sv
module lcd_mux_scan
  import lcd_scan_pkg::*;
#(
  parameter int FRAME_TICKS = 256,
  parameter int COM_N       = 32,
  parameter int SEG_N       = 48,
  localparam int IDX_W = $clog2(COM_N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_on,
  input  logic                   duty32,
  input  logic                   bias7,
  output logic                   ram_rd,
  output logic [IDX_W-1:0]       ram_addr,
  input  logic [SEG_N-1:0]       ram_data,
  output logic [COM_N*LVL_W-1:0] com_lvl,
  output logic [SEG_N*LVL_W-1:0] seg_lvl
);
  logic             pol;
  logic             duty_q;
  logic [IDX_W-1:0] slot_idx;
  logic [IDX_W-1:0] next_idx;
  logic             slot_last;
  logic             prefetch;
  logic             frame_first;
  logic [SEG_N-1:0] row_q;
  logic [COM_N-1:0] com_sel_vec;

  lcd_scan_timebase #(.FRAME_TICKS(FRAME_TICKS), .COM_N(COM_N)) u_tb (
    .clk(clk), .rst_n(rst_n), .duty32(duty32), .pol(pol), .duty_q(duty_q),
    .slot_idx(slot_idx), .next_idx(next_idx), .slot_last(slot_last),
    .prefetch(prefetch), .frame_first(frame_first)
  );

  lcd_scan_fetch #(.COM_N(COM_N), .SEG_N(SEG_N)) u_fetch (
    .clk(clk), .rst_n(rst_n), .prefetch(prefetch), .slot_last(slot_last),
    .next_idx(next_idx), .ram_data(ram_data), .ram_rd(ram_rd),
    .ram_addr(ram_addr), .row_q(row_q)
  );

  lcd_scan_drive #(.COM_N(COM_N), .SEG_N(SEG_N)) u_drive (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .bias7(bias7), .pol(pol),
    .duty_q(duty_q), .slot_idx(slot_idx), .row_q(row_q),
    .com_sel_vec(com_sel_vec), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // R8: display off puts every pin on the ground rail
  a_r8_off_ground: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (com_lvl == '0) && (seg_lvl == '0));
  // R9: read address stays inside the scanned range
  a_r9_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_rd && !duty_q) |-> (ram_addr < IDX_W'(COM_N / 2)));
  // R1: first tick after reset selects common 0
  a_r1_start_com0: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_first && disp_on) |-> com_sel_vec[0]);
endmodule

// File: tb/sim_lcd_mux_scan.sv
module sim_lcd_mux_scan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_on = 1'b1;
  logic duty32 = 1'b0;
  logic bias7 = 1'b0;
  logic ram_rd;
  logic [4:0] ram_addr;
  logic [47:0] ram_data;
  logic [95:0] com_lvl;
  logic [143:0] seg_lvl;

  always #10 clk = ~clk;

  lcd_mux_scan u0 (
    .clk(clk), .rst_n(rst_n), .disp_on(disp_on), .duty32(duty32), .bias7(bias7),
    .ram_rd(ram_rd), .ram_addr(ram_addr), .ram_data(ram_data),
    .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  // display RAM with one tick of read latency
  logic [47:0] mem [32];
  logic [47:0] ram_q = '0;
  assign ram_data = ram_q;
  always @(posedge clk) if (ram_rd) ram_q <= mem[ram_addr];

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt, m_pol, m_d32;
  logic [47:0] m_row;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pol = 0; m_d32 = 0; m_row = '0;
    end else begin
      int slot;
      slot = m_d32 ? 8 : 16;
      if ((m_cnt % slot) == slot - 1) m_row = ram_q;
      if (m_cnt == 255) begin
        m_cnt = 0; m_pol = 1 - m_pol; m_d32 = duty32 ? 1 : 0;
      end else m_cnt = m_cnt + 1;
    end
  end

  function automatic int exp_com(int k, int cnt, int pol, int d32, int b7, int on);
    int a, slot, act;
    a = b7 ? 7 : 5;
    slot = d32 ? 8 : 16;
    act = cnt / slot;
    if (!on) return 0;
    if (k == act) return pol ? 0 : a;
    return pol ? a - 1 : 1;
  endfunction

  function automatic int exp_seg(logic bitv, int pol, int b7, int on);
    int a;
    a = b7 ? 7 : 5;
    if (!on) return 0;
    if (bitv) return pol ? a : 0;
    return pol ? a - 2 : 2;
  endfunction

  logic comparing = 1'b0;

  always @(negedge clk) begin
    if (comparing && rst_n) begin
      logic [95:0] ec;
      logic [143:0] es;
      int slot, pos, nxt;
      logic erd;
      logic [4:0] ea;
      for (int k = 0; k < 32; k++)
        ec[k*3 +: 3] = 3'(exp_com(k, m_cnt, m_pol, m_d32, bias7, disp_on));
      for (int j = 0; j < 48; j++)
        es[j*3 +: 3] = 3'(exp_seg(m_row[j], m_pol, bias7, disp_on));
      slot = m_d32 ? 8 : 16;
      pos = m_cnt % slot;
      nxt = (m_cnt / slot + 1) % (m_d32 ? 32 : 16);
      erd = (pos == slot - 2);
      ea = erd ? 5'(nxt) : 5'd0;
      total += 3;
      if (com_lvl !== ec) begin
        bad++;
        $display("FAIL %s/R11 com_lvl t=%0d actual=%h expected=%h", tag, m_cnt, com_lvl, ec);
      end
      if (seg_lvl !== es) begin
        bad++;
        $display("FAIL %s/R7 seg_lvl t=%0d actual=%h expected=%h", tag, m_cnt, seg_lvl, es);
      end
      if (ram_rd !== erd || ram_addr !== ea) begin
        bad++;
        $display("FAIL %s/R9 ram rd=%b addr=%0d expected rd=%b addr=%0d", tag, ram_rd, ram_addr, erd, ea);
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected<=200000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 32; r++)
      mem[r] = 48'(r * 48'h0123_4567_89AB) ^ {24{r[0], ~r[1]}};
    mem[0] = '1;
    mem[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    comparing = 1'b1;
    // R1: reset state seen directly
    check("R1 com0 select", int'(com_lvl[2:0]), 5);
    check("R1 com1 nonselect", int'(com_lvl[5:3]), 1);
    check("R1 seg0 nonselect", int'(seg_lvl[2:0]), 2);
    tag = "R2"; run(600);
    tag = "R10"; duty32 = 1'b1; run(10);
    // R10: mid-frame change must not move to 8-tick slots yet
    check("R10 com16 idle before frame", int'(com_lvl[50:48]), m_pol ? 4 : 1);
    run(300);
    tag = "R4"; run(600);
    tag = "R6"; bias7 = 1'b1; run(5);
    check("R6 com31 code in 1/7 bias", int'(com_lvl[95:93]),
          exp_com(31, m_cnt, m_pol, m_d32, 1, 1));
    run(300);
    tag = "R5"; run(520);
    tag = "R8"; disp_on = 1'b0; run(3);
    check("R8 com0 ground", int'(com_lvl[2:0]), 0);
    check("R8 seg47 ground", int'(seg_lvl[143:141]), 0);
    run(300);
    disp_on = 1'b1;
    tag = "R3"; duty32 = 1'b0; run(600);
    check("R3 com20 nonselect", int'(com_lvl[62:60]), m_pol ? 6 : 1);
    bias7 = 1'b0; run(520);
    comparing = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule